// File: doc/BRIEF.md
# Dual-Port Mode-Configurable GPIO Controller

This block manages two byte-wide general-purpose I/O ports. Each pin has a stored data bit and two mode bits. Software sets them through a small byte-wide register bus. For every pin, the controller turns these three bits into pad-control signals: an active-high source enable, a sink enable with a two-bit strength code, and a resistive pull-up enable. At most one of these is asserted at any time.

The pad input levels pass through one register stage. A read of a port's data address returns the levels actually present on the pins, not the stored bits. An open-drain line is built by keeping the data and upper mode bits at zero and switching the lower mode bit: the pin then moves between floating and a medium-strength sink. Port 1 can be built narrower than eight pins. Its missing bits cannot be written, never drive their pads and read as zero.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: While reset is held and right after it, every data and mode bit is zero and no pin asserts source, sink or pull-up; the sink strength outputs read 2'b00.
- R2: A pin whose two mode bits are both 0 asserts none of source, sink or pull-up, whatever its data bit.
- R3: With data bit 0, mode pairs (upper,lower) = (1,0), (0,1) and (1,1) assert sink with strength code 2'b01 (low), 2'b10 (medium) and 2'b11 (high) respectively; whenever sink is off the strength code is 2'b00.
- R4: With data bit 1 and lower mode bit 1, the pin asserts source only, whatever the upper mode bit.
- R5: With data bit 1, upper mode bit 1 and lower mode bit 0, the pin asserts pull-up only.
- R6: For each pin, at most one of source, sink and pull-up is asserted.
- R7: A write lands at these byte addresses: 0x00 port-0 data, 0x01 port-1 data, 0x0A port-0 lower mode, 0x0B port-0 upper mode, 0x0C port-1 lower mode, 0x0D port-1 upper mode; bit i of each register controls pin i of its port.
- R8: A read of 0x00 or 0x01 returns the pin levels sampled at the previous clock edge, not the stored data bits.
- R9: Reads of the four mode addresses or of any unmapped address return 0x00; a write to an unmapped address changes no register and no pad output.
- R10: Port-1 bits at or above P1_PINS ignore writes, never drive their pads and read back as 0.
- R11: With data and upper mode bits held at 0, setting the lower mode bit gives a medium sink, and clearing it leaves the pin undriven.
- R12: Pad-control outputs reflect a write from the clock edge that accepts it, with no further latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 16 | Pin levels; bits 7:0 port 0, 15:8 port 1 |
| pad_src_en | output | 16 | Per-pin strong source enable |
| pad_sink_en | output | 16 | Per-pin sink enable |
| pad_sink_str | output | 32 | Per-pin sink strength, pin i at bits 2i+1:2i |
| pad_pull_en | output | 16 | Per-pin resistive pull-up enable |

## Verification
The bench targets the data-bit/mode-bit combinations where a decoder can slip. If it ignored the data bit under mode 00, a floating pin would be driven. If it let the upper mode bit matter when sourcing, a source would turn into a sink or pull-up. If it swapped the low and medium strength codes, open-drain lines would sink at the wrong strength. Readback is driven with external levels that differ from the stored data, so a design that echoes the register instead of the pin gets caught. Writes to unmapped addresses, reads of write-only mode addresses and writes to missing port-1 bits are checked at the pads and the read port, where a loose address decoder or a missing mask would leak stray bits.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
  localparam int PORT_W = 8;
  localparam int NPORTS = 2;

  localparam logic [7:0] A_P0_DATA = 8'h00;
  localparam logic [7:0] A_P1_DATA = 8'h01;
  localparam logic [7:0] A_P0_LO   = 8'h0A;
  localparam logic [7:0] A_P0_HI   = 8'h0B;
  localparam logic [7:0] A_P1_LO   = 8'h0C;
  localparam logic [7:0] A_P1_HI   = 8'h0D;

  typedef enum logic [1:0] {
    SINK_OFF  = 2'b00,
    SINK_LOW  = 2'b01,
    SINK_MED  = 2'b10,
    SINK_HIGH = 2'b11
  } sink_str_e;

  typedef struct packed {
    logic      src;
    logic      sink;
    sink_str_e str;
    logic      pull;
  } pad_ctrl_t;

  // Per-pin decode of data bit and the two mode bits.
  function automatic pad_ctrl_t decode_pin(logic d, logic lo, logic hi);
    pad_ctrl_t c;
    c = '{src: 1'b0, sink: 1'b0, str: SINK_OFF, pull: 1'b0};
    case ({hi, lo})
      2'b00: ;
      2'b01: if (d) c.src = 1'b1;
             else begin c.sink = 1'b1; c.str = SINK_MED; end
      2'b10: if (d) c.pull = 1'b1;
             else begin c.sink = 1'b1; c.str = SINK_LOW; end
      default: if (d) c.src = 1'b1;
             else begin c.sink = 1'b1; c.str = SINK_HIGH; end
    endcase
    return c;
  endfunction

  // Mask of implemented pins for a port with n pins.
  function automatic logic [PORT_W-1:0] pin_mask(int n);
    logic [PORT_W-1:0] m;
    for (int i = 0; i < PORT_W; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pair_pkg::*;
#(
  parameter int          PINS    = 8,
  parameter logic [7:0]  DATA_A  = 8'h00,
  parameter logic [7:0]  LO_A    = 8'h0A,
  parameter logic [7:0]  HI_A    = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] data_q,
  output logic [PORT_W-1:0] lo_q,
  output logic [PORT_W-1:0] hi_q,
  output logic              reg_hit
);
  localparam logic [PORT_W-1:0] IMPL = pin_mask(PINS);

  logic hit_data, hit_lo, hit_hi;
  assign hit_data = wr && (addr == DATA_A);
  assign hit_lo   = wr && (addr == LO_A);
  assign hit_hi   = wr && (addr == HI_A);
  assign reg_hit  = (addr == DATA_A) || (addr == LO_A) || (addr == HI_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (hit_data) data_q <= wdata & IMPL;
      if (hit_lo)   lo_q   <= wdata & IMPL;
      if (hit_hi)   hi_q   <= wdata & IMPL;
    end
  end

  // R7
  data_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_data |=> data_q == ($past(wdata) & IMPL));

  // R10
  unimpl_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_q | lo_q | hi_q) & ~IMPL) == '0);
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
  import gpio_pair_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       d,
  input  logic       lo,
  input  logic       hi,
  output logic       src_en,
  output logic       sink_en,
  output logic [1:0] sink_str,
  output logic       pull_en
);
  pad_ctrl_t ctrl;
  assign ctrl     = decode_pin(d, lo, hi);
  assign src_en   = ctrl.src;
  assign sink_en  = ctrl.sink;
  assign sink_str = ctrl.str;
  assign pull_en  = ctrl.pull;

  // R2
  float_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo && !hi) |-> !(src_en || sink_en || pull_en));

  // R6
  single_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_en, sink_en, pull_en}));

  // R4
  source_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && d) |-> (src_en && !sink_en && !pull_en));

  // R5
  pull_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && !lo && d) |-> (pull_en && !src_en && !sink_en));

  // R3
  strength_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sink_en |-> sink_str == 2'b00);

  // R3
  strength_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sink_en |-> sink_str != 2'b00);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] lvl_in,
  output logic [W-1:0] lvl_q
);
  always_ff @(posedge clk) lvl_q <= lvl_in;
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
  import gpio_pair_pkg::*;
#(
  parameter int P1_PINS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [7:0]                 bus_addr,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  input  logic [NPORTS*PORT_W-1:0]   pad_in,
  output logic [NPORTS*PORT_W-1:0]   pad_src_en,
  output logic [NPORTS*PORT_W-1:0]   pad_sink_en,
  output logic [2*NPORTS*PORT_W-1:0] pad_sink_str,
  output logic [NPORTS*PORT_W-1:0]   pad_pull_en
);
  localparam int NPINS = NPORTS * PORT_W;
  localparam logic [PORT_W-1:0] P1_MASK = pin_mask(P1_PINS);

  logic [PORT_W-1:0] data_q [NPORTS];
  logic [PORT_W-1:0] lo_q   [NPORTS];
  logic [PORT_W-1:0] hi_q   [NPORTS];
  logic [NPORTS-1:0] port_hit;
  logic [NPINS-1:0]  lvl_q;
  logic              any_hit;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gpio_port_regs #(
      .PINS   ((p == 0) ? PORT_W : P1_PINS),
      .DATA_A ((p == 0) ? A_P0_DATA : A_P1_DATA),
      .LO_A   ((p == 0) ? A_P0_LO   : A_P1_LO),
      .HI_A   ((p == 0) ? A_P0_HI   : A_P1_HI)
    ) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .data_q  (data_q[p]),
      .lo_q    (lo_q[p]),
      .hi_q    (hi_q[p]),
      .reg_hit (port_hit[p])
    );

    for (genvar b = 0; b < PORT_W; b++) begin : g_pin
      localparam int IDX = p * PORT_W + b;
      gpio_pin_decode i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .d        (data_q[p][b]),
        .lo       (lo_q[p][b]),
        .hi       (hi_q[p][b]),
        .src_en   (pad_src_en[IDX]),
        .sink_en  (pad_sink_en[IDX]),
        .sink_str (pad_sink_str[2*IDX +: 2]),
        .pull_en  (pad_pull_en[IDX])
      );
    end
  end

  gpio_in_sync #(.W(NPINS)) i_sync (
    .clk    (clk),
    .lvl_in (pad_in),
    .lvl_q  (lvl_q)
  );

  assign any_hit = |port_hit;

  always_comb begin
    case (bus_addr)
      A_P0_DATA: bus_rdata = lvl_q[PORT_W-1:0];
      A_P1_DATA: bus_rdata = lvl_q[NPINS-1:PORT_W] & P1_MASK;
      default:   bus_rdata = '0;
    endcase
  end

  // R9
  unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !any_hit) |=> $stable({pad_src_en, pad_sink_en, pad_sink_str, pad_pull_en}));

  // R9
  mode_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_P0_LO || bus_addr == A_P0_HI ||
     bus_addr == A_P1_LO || bus_addr == A_P1_HI) |-> bus_rdata == 8'h00);

  // R8
  p0_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_P0_DATA) |-> bus_rdata == $past(pad_in[PORT_W-1:0]));

  // R10
  p1_unimpl_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_src_en[NPINS-1:PORT_W] | pad_sink_en[NPINS-1:PORT_W] |
      pad_pull_en[NPINS-1:PORT_W]) & ~P1_MASK) == '0);
endmodule

// File: tb/test_gpio_pair_ctrl.sv
`timescale 1ns/1ps
module test_gpio_pair_ctrl;
  localparam int P1N = 4;
  localparam logic [7:0] P1M = (8'h01 << P1N) - 8'h01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [15:0] pad_in;
  logic [15:0] pad_src_en, pad_sink_en, pad_pull_en;
  logic [31:0] pad_sink_str;
  logic [15:0] ext = 16'h0000;

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  logic [7:0] md [2];
  logic [7:0] ml [2];
  logic [7:0] mh [2];

  always #5 clk = ~clk;

  gpio_pair_ctrl #(.P1_PINS(P1N)) i_gpio_pair_ctrl (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .pad_in, .pad_src_en, .pad_sink_en, .pad_sink_str, .pad_pull_en
  );

  // Pad model built from the control outputs plus an external level.
  always_comb begin
    for (int i = 0; i < 16; i++)
      pad_in[i] = pad_src_en[i] ? 1'b1 : pad_sink_en[i] ? 1'b0 :
                  pad_pull_en[i] ? 1'b1 : ext[i];
  end

  // Expected {src, sink, str[1:0], pull} from the requirement table.
  function automatic logic [4:0] want_pin(logic d, logic lo, logic hi);
    if (!lo && !hi)  return 5'b00000;
    if (d && lo)     return 5'b10000;
    if (d)           return 5'b00001;
    if (hi && lo)    return 5'b01110;
    if (lo)          return 5'b01100;
    return 5'b01010;
  endfunction

  function automatic logic want_level(int i);
    logic [4:0] w;
    w = want_pin(md[i/8][i%8], ml[i/8][i%8], mh[i/8][i%8]);
    if (w[4] || w[0]) return 1'b1;
    if (w[3]) return 1'b0;
    return ext[i];
  endfunction

  function automatic logic [7:0] want_read(logic [7:0] a);
    logic [7:0] r;
    r = 8'h00;
    if (a == 8'h00) for (int b = 0; b < 8; b++) r[b] = want_level(b);
    if (a == 8'h01) begin
      for (int b = 0; b < 8; b++) r[b] = want_level(8 + b);
      r = r & P1M;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pads(string tag);
    logic [15:0] s, k, p;
    logic [31:0] st;
    for (int i = 0; i < 16; i++) begin
      logic [4:0] w;
      w = want_pin(md[i/8][i%8], ml[i/8][i%8], mh[i/8][i%8]);
      s[i] = w[4]; k[i] = w[3]; st[2*i +: 2] = w[2:1]; p[i] = w[0];
    end
    chk({tag, " src"},  {16'h0, pad_src_en},  {16'h0, s});
    chk({tag, " sink"}, {16'h0, pad_sink_en}, {16'h0, k});
    chk({tag, " str"},  pad_sink_str, st);
    chk({tag, " pull"}, {16'h0, pad_pull_en}, {16'h0, p});
  endtask

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    case (a)
      8'h00: md[0] = d;
      8'h01: md[1] = d & P1M;
      8'h0A: ml[0] = d;
      8'h0B: mh[0] = d;
      8'h0C: ml[1] = d & P1M;
      8'h0D: mh[1] = d & P1M;
      default: ;
    endcase
  endtask

  task automatic bus_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic read_check(logic [7:0] a, logic [15:0] e, string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0; ext = e;
    @(posedge clk);
    @(negedge clk);
    chk(tag, {24'h0, bus_rdata}, {24'h0, want_read(a)});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int p = 0; p < 2; p++) begin md[p] = 0; ml[p] = 0; mh[p] = 0; end
    repeat (3) @(negedge clk);
    check_pads("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_pads("R1 after reset");

    // R8: undriven pins read back the external level
    read_check(8'h00, 16'h5AA5, "R8 p0 float readback");
    read_check(8'h01, 16'hC3F6, "R8 R10 p1 float readback");

    // R2: data set but both modes clear
    bus_write(8'h00, 8'hFF);
    check_pads("R2 data high modes off");
    read_check(8'h00, 16'h0000, "R2 R8 stored bits not echoed");

    // R3 R4 R5: all combos on port 0, R12 checked right after the write edge
    bus_write(8'h0A, 8'b1100_1100);
    check_pads("R12 lo write");
    bus_write(8'h0B, 8'b1010_1010);
    bus_write(8'h00, 8'b1111_0000);
    check_pads("R3 R4 R5 combos");
    read_check(8'h00, 16'h0000, "R8 combos level");
    bus_write(8'h00, 8'b0000_1111);
    check_pads("R3 R4 R5 inverted data");
    read_check(8'h00, 16'hFFFF, "R8 combos level inv");

    // R11: open drain on port 0 pin 0
    bus_write(8'h00, 8'h00);
    bus_write(8'h0B, 8'h00);
    bus_write(8'h0A, 8'h01);
    check_pads("R11 od sink");
    chk("R11 od medium code", {30'h0, pad_sink_str[1:0]}, 32'h2);
    bus_write(8'h0A, 8'h00);
    check_pads("R11 od release");
    chk("R11 od floating", {31'h0, pad_sink_en[0]}, 32'h0);

    // R9: unmapped write has no effect; mode and unmapped reads are zero
    bus_write(8'h0A, 8'h3C);
    bus_write(8'h05, 8'hFF);
    bus_write(8'h0E, 8'hFF);
    bus_write(8'h8A, 8'hFF);
    check_pads("R9 unmapped write");
    read_check(8'h0A, 16'hFFFF, "R9 mode read");
    read_check(8'h0D, 16'hFFFF, "R9 mode read hi");
    read_check(8'h42, 16'hFFFF, "R9 unmapped read");

    // R10: missing port-1 bits
    bus_write(8'h01, 8'hFF);
    bus_write(8'h0C, 8'hFF);
    bus_write(8'h0D, 8'hFF);
    check_pads("R10 p1 upper bits");
    chk("R10 p1 top float", {16'h0, pad_src_en[15:8] & ~P1M}, 32'h0);
    read_check(8'h01, 16'hFFFF, "R10 p1 read mask");

    // Random mix, R6 and R7 across the map
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      case ($urandom % 8)
        0: a = 8'h00; 1: a = 8'h01; 2: a = 8'h0A; 3: a = 8'h0B;
        4: a = 8'h0C; 5: a = 8'h0D; default: a = 8'($urandom);
      endcase
      bus_write(a, 8'($urandom));
      check_pads("R6 R7 random");
      for (int i = 0; i < 16; i++)
        if ((pad_src_en[i] + pad_sink_en[i] + pad_pull_en[i]) > 1)
          chk("R6 exclusive", 32'h1, 32'h0);
      read_check(($urandom % 2) ? 8'h01 : (($urandom % 2) ? 8'h00 : 8'($urandom)),
                 16'($urandom), "R8 R9 random read");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule